// File: doc/BRIEF.md
# Firmware Configuration Item Port

This block is a small byte-addressed register port through which boot firmware reads configuration items held inside the device. Firmware writes a 16-bit item number into the selector register, and then pulls the item's bytes out of the data register one at a time. Every byte read advances an internal byte position and counts down the bytes that are left. Once the item is used up, further reads return zero until another item is selected. The item contents come from a small built-in table. The table holds a fixed four-byte signature, a version word that advertises whether descriptor transfers are available, a directory count, and four length words whose values are set by parameters.

The same port also holds a 64-bit descriptor address for a separate transfer engine. The address arrives as two big-endian 32-bit halves. Writing the upper half stores it and clears the lower half. Writing the lower half completes the address and sends it to the engine on a single-cycle doorbell, and then the stored address returns to zero. The engine itself lies outside the block.

The selection logic is a three-state machine. `ST_NONE` means no item is selected. `ST_STREAM` means an item is selected and bytes remain. `ST_DRAINED` means an item is selected and all of its bytes have been read. A selector write to a known item moves any state to `ST_STREAM`. A selector write to an unknown item moves any state to `ST_NONE`. A data read of the last remaining byte moves `ST_STREAM` to `ST_DRAINED`. Reset enters `ST_NONE`.

Top module: `fwcfg_port`

## Requirements
- R1: A selector write (offset 0) takes effect only when `bus_size` is 2. The item number is `bus_wdata[15:0]`. A selector write of any other size leaves the current selection, position and count unchanged.
- R2: A data read (offset 1, `bus_size` 1) of a selected item with bytes remaining returns the next byte in `bus_rdata[7:0]`, with the upper bits zero, in the same cycle. Multi-byte values are sent least-significant byte first. The position advances by one at the clock edge.
- R3: A data read with no item selected, or with no bytes remaining, returns zero and changes nothing.
- R4: Selecting an unknown item number leaves no item selected, so that every following data read returns zero. The known item numbers are 0x0000, 0x0001, 0x0008, 0x000B, 0x0014, 0x0017 and 0x0019.
- R5: A selector write to a known item always restarts at byte 0 with the item's full length, even in the middle of a stream.
- R6: Item 0x0000 returns 4 bytes, in order `SIGNATURE[7:0]`, `[15:8]`, `[23:16]`, `[31:24]`.
- R7: Item 0x0001 returns the 4-byte version word. Bit 0 is always 1, bit 1 equals the `DMA_EN` parameter, and all other bits are 0.
- R8: The length items each return a 4-byte value. Item 0x0008 returns `KERNEL_BYTES`, 0x000B returns `INITRD_BYTES`, 0x0017 returns `SETUP_BYTES`, and 0x0014 returns `CMDLINE_CHARS + 1`, which counts the terminating zero. Item 0x0019 returns four zero bytes.
- R9: A 4-byte write to offset 4 byte-swaps `bus_wdata` from big-endian into address bits 63:32 and clears bits 31:0.
- R10: A 4-byte write to offset 8 ORs the byte-swapped value into bits 31:0. In the next cycle `db_valid` is high for exactly one cycle, with `db_addr` carrying the complete 64-bit address. The stored address then becomes zero.
- R11: A write of any size other than 4 to offset 4 or offset 8 is ignored. It raises no doorbell and leaves the stored address unchanged.
- R12: Writes to the data port are ignored. Reads of the selector return zero. A data read whose size is not 1 returns zero and does not advance the position.
- R13: Reset clears the selection, position, count, stored address and doorbell.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_rd | input | 1 | Read strobe for one cycle |
| bus_off | input | 4 | Byte offset within the 12-byte window |
| bus_size | input | 3 | Access width in bytes (1, 2 or 4) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational during a read strobe |
| db_valid | output | 1 | Single-cycle doorbell to the transfer engine |
| db_addr | output | 64 | Descriptor address carried by the doorbell |

## Verification
The checker watches the port on every cycle. It confirms that a doorbell appears only in the cycle after a full-width low-address write, that the doorbell's low half equals the swapped write data, and that a narrow address write never raises a doorbell. It also confirms that selector reads, narrow data reads and the upper read bits are always zero. The byte contents of every item, the restart on reselection, the ignored narrow selector writes, the ignored data-port writes and the clearing of the stored address are sequences that only the bench scenarios can show. The bench sweeps every selector value from 0x00 to 0x1F, and every selector width.

// File: rtl/fwcfg_pkg.sv
package fwcfg_pkg;

    // Largest item in the table, in bytes
    localparam int ITEM_BYTES = 4;
    localparam int CNT_W      = $clog2(ITEM_BYTES + 1);
    localparam int OFS_W      = $clog2(ITEM_BYTES);

    // Register offsets within the port window
    localparam logic [3:0] OFF_SEL    = 4'd0;
    localparam logic [3:0] OFF_DATA   = 4'd1;
    localparam logic [3:0] OFF_DMA_HI = 4'd4;
    localparam logic [3:0] OFF_DMA_LO = 4'd8;

    // Item numbers that firmware decodes
    localparam logic [15:0] ID_SIGNATURE  = 16'h0000;
    localparam logic [15:0] ID_VERSION    = 16'h0001;
    localparam logic [15:0] ID_KERNEL_LEN = 16'h0008;
    localparam logic [15:0] ID_INITRD_LEN = 16'h000B;
    localparam logic [15:0] ID_CMDLN_LEN  = 16'h0014;
    localparam logic [15:0] ID_SETUP_LEN  = 16'h0017;
    localparam logic [15:0] ID_DIRECTORY  = 16'h0019;

    typedef enum logic [1:0] {
        ST_NONE    = 2'd0,
        ST_STREAM  = 2'd1,
        ST_DRAINED = 2'd2
    } sel_state_t;

    function automatic logic [31:0] swap_be32(input logic [31:0] w);
        return {w[7:0], w[15:8], w[23:16], w[31:24]};
    endfunction

endpackage

// File: rtl/fwcfg_item_rom.sv
module fwcfg_item_rom
    import fwcfg_pkg::*;
#(
    parameter bit          DMA_EN        = 1'b1,
    parameter logic [31:0] SIGNATURE     = 32'h4447_4643,
    parameter logic [31:0] KERNEL_BYTES  = 32'h0012_3456,
    parameter logic [31:0] INITRD_BYTES  = 32'h0000_A5C3,
    parameter logic [31:0] SETUP_BYTES   = 32'h0000_4200,
    parameter int          CMDLINE_CHARS = 37
) (
    input  logic [15:0]      item_id,
    output logic             item_hit,
    output logic [31:0]      item_value,
    output logic [CNT_W-1:0] item_len
);

    localparam logic [CNT_W-1:0] WORD_LEN = CNT_W'(ITEM_BYTES);
    localparam logic [31:0]      CMDLN_SZ = 32'(CMDLINE_CHARS + 1);

    logic [31:0] ver_word;

    generate
        if (DMA_EN) begin : g_ver_dma
            assign ver_word = 32'h0000_0003;
        end else begin : g_ver_legacy
            assign ver_word = 32'h0000_0001;
        end
    endgenerate

    always_comb begin
        item_hit   = 1'b1;
        item_len   = WORD_LEN;
        item_value = '0;
        case (item_id)
            ID_SIGNATURE:  item_value = SIGNATURE;
            ID_VERSION:    item_value = ver_word;
            ID_KERNEL_LEN: item_value = KERNEL_BYTES;
            ID_INITRD_LEN: item_value = INITRD_BYTES;
            ID_CMDLN_LEN:  item_value = CMDLN_SZ;
            ID_SETUP_LEN:  item_value = SETUP_BYTES;
            ID_DIRECTORY:  item_value = '0;
            default: begin
                item_hit = 1'b0;
                item_len = '0;
            end
        endcase
    end

endmodule

// File: rtl/fwcfg_stream.sv
module fwcfg_stream
    import fwcfg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel_fire,
    input  logic             sel_hit,
    input  logic [31:0]      sel_value,
    input  logic [CNT_W-1:0] sel_len,
    input  logic             rd_fire,
    output logic             byte_ok,
    output logic [7:0]       byte_out
);

    sel_state_t       state_q, state_d;
    logic [OFS_W-1:0] ofs_q, ofs_d;
    logic [CNT_W-1:0] left_q, left_d;
    logic [31:0]      value_q, value_d;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_NONE;
            ofs_q   <= '0;
            left_q  <= '0;
            value_q <= '0;
        end else begin
            state_q <= state_d;
            ofs_q   <= ofs_d;
            left_q  <= left_d;
            value_q <= value_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        ofs_d   = ofs_q;
        left_d  = left_q;
        value_d = value_q;
        if (sel_fire) begin
            ofs_d = '0;
            if (sel_hit) begin
                state_d = (sel_len == '0) ? ST_DRAINED : ST_STREAM;
                left_d  = sel_len;
                value_d = sel_value;
            end else begin
                state_d = ST_NONE;
                left_d  = '0;
                value_d = '0;
            end
        end else if (rd_fire) begin
            unique case (state_q)
                ST_STREAM: begin
                    ofs_d  = OFS_W'(ofs_q + 1'b1);
                    left_d = CNT_W'(left_q - 1'b1);
                    if (left_q == CNT_W'(1)) state_d = ST_DRAINED;
                end
                ST_NONE, ST_DRAINED: ;
                default: state_d = ST_NONE;
            endcase
        end
    end

    // Outputs
    always_comb begin
        byte_ok  = (state_q == ST_STREAM);
        byte_out = 8'(value_q >> {ofs_q, 3'b000});
    end

endmodule

// File: rtl/fwcfg_dma_addr.sv
module fwcfg_dma_addr
    import fwcfg_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        hi_fire,
    input  logic        lo_fire,
    input  logic [31:0] wr_word,
    output logic        db_valid,
    output logic [63:0] db_addr
);

    logic [63:0] addr_q;
    logic [31:0] host_word;

    assign host_word = swap_be32(wr_word);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q   <= '0;
            db_valid <= 1'b0;
            db_addr  <= '0;
        end else begin
            db_valid <= 1'b0;
            if (hi_fire) begin
                addr_q <= {host_word, 32'h0};
            end else if (lo_fire) begin
                db_valid <= 1'b1;
                db_addr  <= addr_q | {32'h0, host_word};
                addr_q   <= '0;
            end
        end
    end

endmodule

// File: rtl/fwcfg_port.sv
module fwcfg_port
    import fwcfg_pkg::*;
#(
    parameter bit          DMA_EN        = 1'b1,
    parameter logic [31:0] SIGNATURE     = 32'h4447_4643,
    parameter logic [31:0] KERNEL_BYTES  = 32'h0012_3456,
    parameter logic [31:0] INITRD_BYTES  = 32'h0000_A5C3,
    parameter logic [31:0] SETUP_BYTES   = 32'h0000_4200,
    parameter int          CMDLINE_CHARS = 37
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [3:0]  bus_off,
    input  logic [2:0]  bus_size,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        db_valid,
    output logic [63:0] db_addr
);

    logic             sel_fire, rd_fire, hi_fire, lo_fire;
    logic             item_hit, byte_ok;
    logic [31:0]      item_value;
    logic [CNT_W-1:0] item_len;
    logic [7:0]       byte_out;

    // Size-qualified decode; writes take priority over reads
    assign sel_fire = bus_wr && bus_off == OFF_SEL    && bus_size == 3'd2;
    assign hi_fire  = bus_wr && bus_off == OFF_DMA_HI && bus_size == 3'd4;
    assign lo_fire  = bus_wr && bus_off == OFF_DMA_LO && bus_size == 3'd4;
    assign rd_fire  = bus_rd && !bus_wr && bus_off == OFF_DATA && bus_size == 3'd1;

    fwcfg_item_rom #(
        .DMA_EN        (DMA_EN),
        .SIGNATURE     (SIGNATURE),
        .KERNEL_BYTES  (KERNEL_BYTES),
        .INITRD_BYTES  (INITRD_BYTES),
        .SETUP_BYTES   (SETUP_BYTES),
        .CMDLINE_CHARS (CMDLINE_CHARS)
    ) i_rom (
        .item_id    (bus_wdata[15:0]),
        .item_hit   (item_hit),
        .item_value (item_value),
        .item_len   (item_len)
    );

    fwcfg_stream i_stream (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel_fire  (sel_fire),
        .sel_hit   (item_hit),
        .sel_value (item_value),
        .sel_len   (item_len),
        .rd_fire   (rd_fire),
        .byte_ok   (byte_ok),
        .byte_out  (byte_out)
    );

    fwcfg_dma_addr i_dma (
        .clk      (clk),
        .rst_n    (rst_n),
        .hi_fire  (hi_fire),
        .lo_fire  (lo_fire),
        .wr_word  (bus_wdata),
        .db_valid (db_valid),
        .db_addr  (db_addr)
    );

    assign bus_rdata = (rd_fire && byte_ok) ? {24'h0, byte_out} : 32'h0;

endmodule

// File: rtl/fwcfg_port_chk.sv
module fwcfg_port_chk
    import fwcfg_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        bus_wr,
    input logic        bus_rd,
    input logic [3:0]  bus_off,
    input logic [2:0]  bus_size,
    input logic [31:0] bus_wdata,
    input logic [31:0] bus_rdata,
    input logic        db_valid,
    input logic [63:0] db_addr
);

    logic lo_full, lo_narrow;
    assign lo_full   = bus_wr && bus_off == OFF_DMA_LO && bus_size == 3'd4;
    assign lo_narrow = bus_wr && (bus_off == OFF_DMA_LO || bus_off == OFF_DMA_HI) && bus_size != 3'd4;

    p_db_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
        db_valid |-> $past(lo_full));

    p_db_low_half_r10: assert property (@(posedge clk) disable iff (!rst_n)
        db_valid |-> db_addr[31:0] == swap_be32($past(bus_wdata)));

    p_narrow_addr_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
        lo_narrow |=> !db_valid);

    p_selector_read_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && !bus_wr && bus_off == OFF_SEL) |-> bus_rdata == 32'h0);

    p_narrow_data_read_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_off == OFF_DATA && bus_size != 3'd1) |-> bus_rdata == 32'h0);

    p_byte_lane_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[31:8] == 24'h0);

endmodule

bind fwcfg_port fwcfg_port_chk i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_off   (bus_off),
    .bus_size  (bus_size),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .db_valid  (db_valid),
    .db_addr   (db_addr)
);

// File: tb/test_fwcfg_port.sv
module test_fwcfg_port;

    localparam bit          P_DMA    = 1'b1;
    localparam logic [31:0] P_SIG    = 32'h4447_4643;
    localparam logic [31:0] P_KERNEL = 32'h0012_3456;
    localparam logic [31:0] P_INITRD = 32'h0000_A5C3;
    localparam logic [31:0] P_SETUP  = 32'h0000_4200;
    localparam int          P_CMDLN  = 37;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [3:0]  bus_off = '0;
    logic [2:0]  bus_size = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        db_valid;
    logic [63:0] db_addr;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    fwcfg_port #(
        .DMA_EN (P_DMA), .SIGNATURE (P_SIG), .KERNEL_BYTES (P_KERNEL),
        .INITRD_BYTES (P_INITRD), .SETUP_BYTES (P_SETUP), .CMDLINE_CHARS (P_CMDLN)
    ) i_fwcfg_port (
        .clk (clk), .rst_n (rst_n), .bus_wr (bus_wr), .bus_rd (bus_rd),
        .bus_off (bus_off), .bus_size (bus_size), .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata), .db_valid (db_valid), .db_addr (db_addr)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Expected item contents computed from the requirements
    task automatic model_item(input logic [15:0] id, output bit hit, output logic [31:0] val);
        hit = 1'b1;
        case (id)
            16'h0000: val = P_SIG;
            16'h0001: val = 32'h1 | (32'(P_DMA) << 1);
            16'h0008: val = P_KERNEL;
            16'h000B: val = P_INITRD;
            16'h0014: val = 32'(P_CMDLN + 1);
            16'h0017: val = P_SETUP;
            16'h0019: val = 32'h0;
            default: begin hit = 1'b0; val = 32'h0; end
        endcase
    endtask

    task automatic bus_op(input logic wr, input logic [3:0] off, input logic [2:0] sz,
                          input logic [31:0] wd, output logic [31:0] rd);
        @(negedge clk);
        bus_wr = wr; bus_rd = !wr; bus_off = off; bus_size = sz; bus_wdata = wd;
        #2 rd = bus_rdata;
        @(posedge clk);
        #1 bus_wr = 1'b0; bus_rd = 1'b0;
    endtask

    task automatic wr(input logic [3:0] off, input logic [2:0] sz, input logic [31:0] wd);
        logic [31:0] unused_rd;
        bus_op(1'b1, off, sz, wd, unused_rd);
    endtask

    task automatic rd_byte(output logic [31:0] rd);
        bus_op(1'b0, 4'd1, 3'd1, 32'h0, rd);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        logic [31:0] v;
        bit hit;

        do_reset();
        // R13: reset state
        check("R13 doorbell idle", {63'h0, db_valid}, 64'h0);
        rd_byte(r);
        check("R13 no selection after reset", {32'h0, r}, 64'h0);

        // Sweep every selector value 0x00..0x1F: R2 R3 R4 R6 R7 R8
        for (int id = 0; id < 32; id++) begin
            model_item(16'(id), hit, v);
            wr(4'd0, 3'd2, 32'(id));
            for (int k = 0; k < 6; k++) begin
                rd_byte(r);
                if (hit && k < 4)
                    check($sformatf("R2/R6/R7/R8 item %0h byte %0d", id, k), {32'h0, r}, {56'h0, 8'(v >> (8 * k))});
                else if (hit)
                    check($sformatf("R3 item %0h drained byte %0d", id, k), {32'h0, r}, 64'h0);
                else
                    check($sformatf("R4 unknown item %0h byte %0d", id, k), {32'h0, r}, 64'h0);
            end
        end

        // R1: selector writes of every width other than 2 are ignored mid-stream
        wr(4'd0, 3'd2, 32'h0000);
        rd_byte(r);
        check("R1 first signature byte", {32'h0, r}, {56'h0, P_SIG[7:0]});
        for (int sz = 0; sz < 8; sz++) begin
            if (sz != 2) wr(4'd0, 3'(sz), 32'h0001);
        end
        rd_byte(r);
        check("R1 narrow or wide selector ignored", {32'h0, r}, {56'h0, P_SIG[15:8]});

        // R5: reselect restarts at byte 0
        wr(4'd0, 3'd2, 32'h0000);
        rd_byte(r);
        check("R5 restart at byte 0", {32'h0, r}, {56'h0, P_SIG[7:0]});

        // R4: unknown selector mid-stream clears selection
        wr(4'd0, 3'd2, 32'h0008);
        rd_byte(r);
        wr(4'd0, 3'd2, 32'h0011);
        rd_byte(r);
        check("R4 unknown clears selection", {32'h0, r}, 64'h0);

        // R12: data-port writes, narrow data reads and selector reads
        wr(4'd0, 3'd2, 32'h0008);
        rd_byte(r);
        check("R12 kernel byte 0", {32'h0, r}, {56'h0, P_KERNEL[7:0]});
        wr(4'd1, 3'd1, 32'hFF);
        wr(4'd1, 3'd4, 32'h0000_0001);
        bus_op(1'b0, 4'd1, 3'd2, 32'h0, r);
        check("R12 narrow data read zero", {32'h0, r}, 64'h0);
        bus_op(1'b0, 4'd0, 3'd2, 32'h0, r);
        check("R12 selector read zero", {32'h0, r}, 64'h0);
        rd_byte(r);
        check("R12 stream unaffected", {32'h0, r}, {56'h0, P_KERNEL[15:8]});

        // R9 R10: doorbell with full address
        wr(4'd4, 3'd4, 32'h1122_3344);
        wr(4'd8, 3'd4, 32'hAABB_CCDD);
        check("R10 doorbell raised", {63'h0, db_valid}, 64'h1);
        check("R9/R10 doorbell address", db_addr, 64'h4433_2211_DDCC_BBAA);
        @(posedge clk); #1;
        check("R10 doorbell one cycle", {63'h0, db_valid}, 64'h0);
        wr(4'd8, 3'd4, 32'h0100_0000);
        check("R10 address cleared after doorbell", db_addr, 64'h0000_0000_0000_0001);

        // R11: narrow address writes ignored
        wr(4'd4, 3'd4, 32'h0000_0080);
        wr(4'd4, 3'd2, 32'hFFFF_FFFF);
        wr(4'd8, 3'd2, 32'hFFFF_FFFF);
        check("R11 narrow low write no doorbell", {63'h0, db_valid}, 64'h0);
        wr(4'd8, 3'd1, 32'hFFFF_FFFF);
        check("R11 byte low write no doorbell", {63'h0, db_valid}, 64'h0);
        wr(4'd8, 3'd4, 32'h0000_0000);
        check("R11 stored address kept", db_addr, 64'h8000_0000_0000_0000);

        // R13: reset mid-stream and with a pending high half
        wr(4'd0, 3'd2, 32'h0001);
        rd_byte(r);
        wr(4'd4, 3'd4, 32'h5555_5555);
        do_reset();
        rd_byte(r);
        check("R13 selection cleared", {32'h0, r}, 64'h0);
        wr(4'd8, 3'd4, 32'h0000_0002);
        check("R13 address cleared", db_addr, 64'h0000_0000_0200_0000);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule